// File: doc/BRIEF.md
# Linked-List Descriptor Loader

This unit sits beside one DMA channel's register file. When the channel finishes a block, the channel asserts a start strobe. The loader then reads the channel's current link word and base word and decides whether another descriptor follows. If it does, the loader fetches that descriptor from memory one word at a time and writes each returned word into the matching channel register.

The link word carries six update flags and a word-aligned 16-bit offset. The base word carries the upper half of the descriptor address. Only the registers whose flags are set are read. They are read in a fixed order from consecutive word addresses, and a register that is not flagged costs neither a read nor an address slot. The loader signals its outcome with one of three pulses. The first says the link register was reloaded and the channel goes on with the new descriptor. The second says the channel is finished. The third reports a bus error on a descriptor read.

Top module: `ll_desc_loader`

## Requirements
- R1: The first descriptor read goes to the address built from base_i[31:16] as the upper half, link_i[15:2] as bits 15 to 2, and zero in bits 1 and 0.
- R2: The link word's flags are bit 31 for transfer config 1, bit 30 for transfer config 2, bit 29 for block count, bit 28 for source address, bit 27 for destination address, and bit 16 for the link register. Flagged registers are fetched in that order and written with wr_sel codes 0, 1, 2, 3, 4 and 5 respectively.
- R3: Only flagged registers are read. Each read goes to the previous read address plus 4, so an unflagged register consumes no address.
- R4: When none of the six flags is set, whatever the offset, final_o pulses in the cycle after start_i is taken, with no memory read and no register write.
- R5: After the last flagged word, next_o pulses if the link register flag was set, and final_o pulses otherwise. The pulse falls in the same cycle as the last register write.
- R6: A response with mem_rerr_i high causes an lerr_o pulse. It writes no register, issues no further read, and produces neither next_o nor final_o.
- R7: mem_req_o stays high with mem_addr_o unchanged from the cycle a read is issued until the cycle its mem_rvalid_i response arrives.
- R8: start_i has no effect while busy_o is high, including in the cycle of the final response.
- R9: After reset, busy_o, mem_req_o, wr_en_o, next_o, final_o and lerr_o are all low.
- R10: Link word bits 0, 1 and 17 to 26, and base word bits 0 to 15, do not affect the loader's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Block completed; evaluate the link word |
| base_i | input | 32 | Base register; the upper half forms the descriptor address |
| link_i | input | 32 | Link register: update flags and word offset |
| busy_o | output | 1 | Descriptor fetch in progress |
| mem_req_o | output | 1 | Read request, held until the response |
| mem_addr_o | output | 32 | Read word address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_rerr_i | input | 1 | Read response carries a bus error |
| wr_en_o | output | 1 | Channel register write strobe |
| wr_sel_o | output | 3 | Target register code |
| wr_data_o | output | 32 | Word to write |
| next_o | output | 1 | Descriptor loaded and link reloaded; channel continues |
| final_o | output | 1 | Channel completes |
| lerr_o | output | 1 | Link update error |

## Verification
Two things can land in one cycle: the response to the last flagged word, which ends the fetch, and a fresh start strobe from the channel. The bench provokes this by holding start_i high through the whole fetch while it changes link_i to a different word. As a result, start_i is also present on the edge that consumes the final response. The scoreboard then must see exactly the expected writes and one end pulse, with no further memory reads. Any extra write, extra pulse or extra read shows that a start strobe leaked into a busy or just-finishing loader.

// File: rtl/ll_desc_loader.sv
module ll_desc_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] base_i,
  input  logic [31:0] link_i,
  output logic        busy_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_rerr_i,
  output logic        wr_en_o,
  output logic [2:0]  wr_sel_o,
  output logic [31:0] wr_data_o,
  output logic        next_o,
  output logic        final_o,
  output logic        lerr_o
);
  localparam int NREG = 6;
  localparam int SW   = $clog2(NREG);

  logic [NREG-1:0] pend;
  logic [31:0]     addr;
  logic            busy;
  logic            link_upd;
  logic [SW-1:0]   cur_idx;
  logic [NREG-1:0] cur_oh;
  logic [NREG-1:0] pend_nx;

  // index 0 is fetched first
  wire [NREG-1:0] flags = {link_i[16], link_i[27], link_i[28],
                           link_i[29], link_i[30], link_i[31]};
  wire [31:0] first_addr = {base_i[31:16], link_i[15:2], 2'b00};
  wire unused_bits = ^{base_i[15:0], link_i[26:17], link_i[1:0]};

  always_comb begin
    cur_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (pend[i]) cur_idx = SW'(i);
  end

  assign cur_oh    = NREG'(1) << cur_idx;
  assign pend_nx   = pend & ~cur_oh;
  assign busy_o    = busy;
  assign mem_req_o = busy;
  assign mem_addr_o = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend      <= '0;
      addr      <= '0;
      link_upd  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_sel_o  <= '0;
      wr_data_o <= '0;
      next_o    <= 1'b0;
      final_o   <= 1'b0;
      lerr_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      next_o  <= 1'b0;
      final_o <= 1'b0;
      lerr_o  <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          if (flags == '0) begin
            final_o <= 1'b1;
          end else begin
            busy     <= 1'b1;
            pend     <= flags;
            addr     <= first_addr;
            link_upd <= link_i[16];
          end
        end
      end else if (mem_rvalid_i) begin
        if (mem_rerr_i) begin
          lerr_o <= 1'b1;
          busy   <= 1'b0;
          pend   <= '0;
        end else begin
          wr_en_o   <= 1'b1;
          wr_sel_o  <= 3'(cur_idx);
          wr_data_o <= mem_rdata_i;
          pend      <= pend_nx;
          addr      <= addr + 32'd4;
          if (pend_nx == '0) begin
            busy <= 1'b0;
            if (link_upd) next_o  <= 1'b1;
            else          final_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ll_desc_loader_chk.sv
module ll_desc_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] base_i,
  input logic [31:0] link_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic [31:0] mem_rdata_i,
  input logic        mem_rerr_i,
  input logic        wr_en_o,
  input logic [2:0]  wr_sel_o,
  input logic [31:0] wr_data_o,
  input logic        next_o,
  input logic        final_o,
  input logic        lerr_o
);
  wire unused_chk = ^{base_i, mem_rdata_i, wr_data_o, wr_sel_o};

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rvalid_i && !mem_rerr_i) |=>
      (!mem_req_o || mem_addr_o == $past(mem_addr_o) + 32'd4));

  p_no_flags_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && link_i[31:27] == 5'd0 && !link_i[16]) |=>
      (final_o && !mem_req_o && !wr_en_o));

  p_one_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({next_o, final_o, lerr_o}));

  p_end_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (next_o || final_o) |-> !busy_o);

  p_err_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rvalid_i && mem_rerr_i) |=>
      (lerr_o && !wr_en_o && !mem_req_o));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !mem_rvalid_i) |=> (busy_o && $stable(mem_addr_o)));
endmodule

bind ll_desc_loader ll_desc_loader_chk u_chk (.*);

// File: tb/tb_ll_desc_loader.sv
`timescale 1ns/1ps
module tb_ll_desc_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [31:0] link_i = '0;
  logic        busy_o, mem_req_o, wr_en_o, next_o, final_o, lerr_o;
  logic [31:0] mem_addr_o, wr_data_o;
  logic [2:0]  wr_sel_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_rerr_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int reads  = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  string       tag = "R9";
  logic [36:0] exp_q[$];

  always #5 clk = ~clk;

  ll_desc_loader dut (.*);

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string t, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, expv);
    end
  endtask

  // memory model: one response per held request
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      mem_rerr_i   = 1'b0;
      if (mem_req_o) begin
        repeat (lat) @(negedge clk);
        mem_rdata_i  = mdata(mem_addr_o);
        mem_rerr_i   = err_en && (mem_addr_o == err_addr);
        mem_rvalid_i = 1'b1;
        reads++;
      end
    end
  end

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (wr_en_o) pop_cmp({2'd0, wr_sel_o, wr_data_o});
        if (next_o)  pop_cmp({2'd1, 3'd0, 32'd0});
        if (final_o) pop_cmp({2'd2, 3'd0, 32'd0});
        if (lerr_o)  pop_cmp({2'd3, 3'd0, 32'd0});
      end
    end
  end

  task automatic pop_cmp(input logic [36:0] act);
    logic [36:0] e;
    if (exp_q.size() == 0) begin
      check(1'b0, {tag, " unexpected output"}, 64'(act), 64'h0);
    end else begin
      e = exp_q.pop_front();
      check(act == e, tag, 64'(act), 64'(e));
    end
  endtask

  // driver: predict, then stimulate
  task automatic run(input logic [31:0] base, input logic [31:0] link, input int l,
                     input int err_at, input bit hold, input string t);
    int fl[6];
    int n = 0;
    bit any = 0;
    bit stopped = 0;
    int r0;
    logic [31:0] a0;
    fl[0] = link[31]; fl[1] = link[30]; fl[2] = link[29];
    fl[3] = link[28]; fl[4] = link[27]; fl[5] = link[16];
    a0 = {base[31:16], link[15:2], 2'b00};
    tag = t;
    lat = l;
    err_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (fl[k] != 0 && !stopped) begin
        any = 1;
        if (n == err_at) begin
          err_en = 1'b1;
          err_addr = a0 + 32'(4 * n);
          exp_q.push_back({2'd3, 3'd0, 32'd0});
          stopped = 1;
        end else begin
          exp_q.push_back({2'd0, 3'(k), mdata(a0 + 32'(4 * n))});
        end
        n++;
      end
    end
    if (!stopped) begin
      if (any && fl[5] != 0) exp_q.push_back({2'd1, 3'd0, 32'd0});
      else                   exp_q.push_back({2'd2, 3'd0, 32'd0});
    end
    r0 = reads;
    @(negedge clk);
    base_i = base;
    link_i = link;
    start_i = 1'b1;
    @(negedge clk);
    if (hold) begin
      link_i = 32'hFFFF_FFFF;
      while (busy_o) @(negedge clk);
    end
    start_i = 1'b0;
    for (int w = 0; w < 200 && (exp_q.size() != 0 || busy_o); w++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {t, " pending items"}, 64'(exp_q.size()), 64'd0);
    check(reads - r0 == n, {t, " read count"}, 64'(reads - r0), 64'(n));
    check(!busy_o && !mem_req_o, {t, " idle after"}, {62'd0, busy_o, mem_req_o}, 64'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check({busy_o, mem_req_o, wr_en_o, next_o, final_o, lerr_o} == 6'd0, "R9 reset",
          64'({busy_o, mem_req_o, wr_en_o, next_o, final_o, lerr_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy_o, mem_req_o, wr_en_o, next_o, final_o, lerr_o} == 6'd0, "R9 after release",
          64'({busy_o, mem_req_o, wr_en_o, next_o, final_o, lerr_o}), 64'd0);
    // R1 R2 R5: all flags, link reload -> next
    run(32'h2000_1234, 32'hF801_0040, 0, -1, 0, "R1 R2 R5 all flags");
    // R3 R5: subset without link flag, latency 2 -> final
    run(32'h3000_0000, 32'h5000_0100, 2, -1, 0, "R3 R5 subset");
    // R3: sparse flags with offset zero
    run(32'h4444_FFFF, 32'h8801_0000, 1, -1, 0, "R1 R3 sparse");
    // R4 zero word
    run(32'h5000_0000, 32'h0000_0000, 0, -1, 0, "R4 zero word");
    // R4 offset without flags
    run(32'h5000_0000, 32'h0000_0FFC, 0, -1, 0, "R4 offset only");
    // R10 ignored bits only
    run(32'h6000_0000, 32'h07FE_0003, 0, -1, 0, "R10 ignored bits");
    // R10 ignored bits mixed with flags
    run(32'h7000_ABCD, 32'h27FF_0013, 1, -1, 0, "R10 mixed bits");
    // R6 error on third read
    run(32'h8000_0000, 32'hF801_0200, 0, 2, 0, "R6 error third");
    // R6 error on first read
    run(32'h9000_0000, 32'h1001_0300, 1, 0, 0, "R6 error first");
    // R8 start held through busy, incl. final response cycle
    run(32'hA000_0000, 32'h2001_0400, 1, -1, 1, "R8 held start");
    run(32'hB000_0000, 32'hC000_FFF0, 0, -1, 1, "R8 R7 held start no wait");
    // R5 link only
    run(32'hC000_0000, 32'h0001_0010, 3, -1, 0, "R5 link only");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule